// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a single-port, word-organised synchronous memory with a 32-bit data path split into four byte lanes. Reads and writes can be issued on every enabled clock edge, in any mix, with no idle cycles between a write and a following read. Commands (address, chip selects, load strobe, write enable) are registered on the rising edge. Read data leaves an output register one enabled edge after the command. Write data and its byte mask are taken two enabled edges after the write command. That delay lets the data bus turn around without dead cycles and requires a two-stage pipeline of pending write addresses.

A read whose output is loaded at the same edge as an earlier write to the same word receives that write's bytes merged over the stored word. A clock enable input freezes every register and suppresses writes, so a stalled edge simply lengthens the previous cycle. The shared bus is modelled as separate data-in, data-out and output-enable ports.

Top module: `zbt_sram`

## Requirements
- R1: After reset, dq_oe_o is 0 and dq_o is 0, and no read or write is pending.
- R2: A read is issued at an enabled edge when cen_ni=0, ce1_ni=0, ce2_i=1, ce3_ni=0, adv_ld_i=0 and we_ni=1. Its word appears on dq_o with dq_oe_o=1 after the next enabled edge.
- R3: A write is issued under the same select conditions with we_ni=0. Its data on dq_i and its mask on bw_ni are sampled at the second enabled edge after issue, and a later read returns the written word.
- R4: bw_ni[k]=0 at the data edge updates lane k (bits 8k+7..8k) only. Lanes with bw_ni[k]=1 keep their previous contents.
- R5: A write whose data edge sees bw_ni=4'hF changes no byte of the word.
- R6: At an enabled edge where any chip select is inactive or adv_ld_i=1, no access starts. dq_oe_o is 0 after the next enabled edge, and a write command given this way leaves memory unchanged.
- R7: At an edge with cen_ni=1, dq_o, dq_oe_o and every pending operation hold, and no byte is written. A pending write takes its data at the next enabled edge instead.
- R8: Reads and writes issued back to back on every enabled edge, in any order, each return or store the correct word.
- R9: A read whose output edge coincides with the data edge of a write to the same address returns the write's enabled lanes merged over the stored word.
- R10: dq_oe_o is 0 during the cycle in which a write's data is expected on dq_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low; high stalls everything |
| ce1_ni | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| ce3_ni | input | 1 | Chip select, active low |
| adv_ld_i | input | 1 | Load strobe; low starts a new access |
| we_ni | input | 1 | Write enable, active low |
| bw_ni | input | 4 | Byte-lane write selects, active low, sampled with write data |
| addr_i | input | AW | Word address |
| dq_i | input | 32 | Write data bus |
| dq_o | output | 32 | Read data from the output register |
| dq_oe_o | output | 1 | Output drive enable for dq_o |

## Verification
On every cycle the assertions check several relations: a stalled edge leaves dq_o, dq_oe_o and the pending operations unchanged, and a registered read raises the output enable. They also check that the enable is low while a write's data is due, that a deselected or non-loading edge queues nothing, and that a full-mask write that coincides with a read of the same word forwards the new data. Only the bench's scenarios can show that values actually land in memory with the right byte lanes and survive a write abort. The same holds for ignored commands given with a chip select off, for the write that lands after a stall, and for random back-to-back traffic matching a reference array.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned WORD_W    = NUM_LANES * LANE_W;
  localparam int unsigned WR_STAGES = 2;

  typedef struct packed {
    logic vld;
    logic wr;
  } op_t;
endpackage

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
  import zbt_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o
);
  op_t           stg_op   [WR_STAGES];
  logic [AW-1:0] stg_addr [WR_STAGES];

  op_t in_op;
  always_comb begin
    in_op.vld = sel_i;
    in_op.wr  = sel_i & ~we_ni;
  end

  for (genvar s = 0; s < WR_STAGES; s++) begin : g_stg
    op_t           nxt_op;
    logic [AW-1:0] nxt_addr;
    if (s == 0) begin : g_head
      assign nxt_op   = in_op;
      assign nxt_addr = addr_i;
    end else begin : g_tail
      assign nxt_op   = stg_op[s-1];
      assign nxt_addr = stg_addr[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_op[s]   <= '0;
        stg_addr[s] <= '0;
      end else if (en_i) begin
        stg_op[s]   <= nxt_op;
        stg_addr[s] <= nxt_addr;
      end
    end
  end

  assign rd_req_o  = stg_op[0].vld & ~stg_op[0].wr;
  assign rd_addr_o = stg_addr[0];
  assign wr_req_o  = stg_op[WR_STAGES-1].vld & stg_op[WR_STAGES-1].wr;
  assign wr_addr_o = stg_addr[WR_STAGES-1];

  // R6: idle edges queue nothing
  p_idle_queues_nothing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sel_i) |=> !stg_op[0].vld);
endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array
  import zbt_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic [NUM_LANES-1:0] wr_be_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [WORD_W-1:0]    rd_data_o
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_be_i[k])
        lane_mem[wr_addr_i] <= wr_data_i[k*LANE_W +: LANE_W];
    end
    assign rd_data_o[k*LANE_W +: LANE_W] = lane_mem[rd_addr_i];
  end
endmodule

// File: rtl/zbt_read_out.sv
module zbt_read_out
  import zbt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 rd_req_i,
  input  logic [WORD_W-1:0]    arr_data_i,
  input  logic                 byp_hit_i,
  input  logic [WORD_W-1:0]    byp_data_i,
  input  logic [NUM_LANES-1:0] byp_be_i,
  output logic [WORD_W-1:0]    dq_o,
  output logic                 oe_o
);
  logic [WORD_W-1:0] merged;

  // write landing at the same edge overrides stored bytes lane by lane
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_merge
    assign merged[k*LANE_W +: LANE_W] = (byp_hit_i && byp_be_i[k])
      ? byp_data_i[k*LANE_W +: LANE_W] : arr_data_i[k*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o <= '0;
      oe_o <= 1'b0;
    end else if (en_i) begin
      oe_o <= rd_req_i;
      if (rd_req_i) dq_o <= merged;
    end
  end

  // R9: full-mask forwarding
  p_forward_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_req_i && byp_hit_i && (&byp_be_i)) |=> (dq_o == $past(byp_data_i)));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cen_ni,
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 adv_ld_i,
  input  logic                 we_ni,
  input  logic [NUM_LANES-1:0] bw_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [WORD_W-1:0]    dq_i,
  output logic [WORD_W-1:0]    dq_o,
  output logic                 dq_oe_o
);
  logic          en, sel;
  logic          rd_req, wr_req, wr_fire, byp_hit;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [WORD_W-1:0] arr_rd;
  logic [NUM_LANES-1:0] be;

  assign en      = ~cen_ni;
  assign sel     = ~ce1_ni & ce2_i & ~ce3_ni & ~adv_ld_i;
  assign be      = ~bw_ni;
  assign wr_fire = en & wr_req;
  assign byp_hit = wr_fire & (wr_addr == rd_addr);

  zbt_cmd_pipe #(.AW(AW)) u_cmd (
    .clk_i, .rst_ni, .en_i(en), .sel_i(sel), .we_ni, .addr_i,
    .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr)
  );

  zbt_mem_array #(.DEPTH(DEPTH)) u_mem (
    .clk_i, .wr_en_i(wr_fire), .wr_addr_i(wr_addr), .wr_data_i(dq_i),
    .wr_be_i(be), .rd_addr_i(rd_addr), .rd_data_o(arr_rd)
  );

  zbt_read_out u_rdo (
    .clk_i, .rst_ni, .en_i(en), .rd_req_i(rd_req), .arr_data_i(arr_rd),
    .byp_hit_i(byp_hit), .byp_data_i(dq_i), .byp_be_i(be),
    .dq_o, .oe_o(dq_oe_o)
  );

  // R7: stalled edge freezes outputs and pipeline
  p_stall_hold_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(dq_o) && $stable(dq_oe_o)));
  p_stall_hold_pipe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(rd_req) && $stable(wr_req) && $stable(wr_addr)));
  // R2: registered read drives the bus next
  p_read_drives_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && rd_req) |=> dq_oe_o);
  // R10: no drive while write data is due
  p_write_slot_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req |-> !dq_oe_o);
endmodule

// File: tb/sim_zbt_sram.sv
module sim_zbt_sram;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cen_ni = 1'b1, ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic        adv_ld_i = 1'b0, we_ni = 1'b1;
  logic [3:0]  bw_ni = 4'hF;
  logic [7:0]  addr_i = '0;
  logic [31:0] dq_i = '0;
  logic [31:0] dq_o;
  logic        dq_oe_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  zbt_sram #(.DEPTH(256)) u0 (
    .clk_i(clk), .rst_ni, .cen_ni, .ce1_ni, .ce2_i, .ce3_ni, .adv_ld_i,
    .we_ni, .bw_ni, .addr_i, .dq_i, .dq_o, .dq_oe_o
  );

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] ref_mem [256];
  logic b1_vld = 0, b1_wr = 0, b2_vld = 0, b2_wr = 0;
  logic [7:0]  b1_a = '0, b2_a = '0;
  logic [31:0] b1_d = '0, b2_d = '0;
  logic [3:0]  b1_bw = '1, b2_bw = '1;
  string       b1_tag = "", b2_tag = "";
  logic        exp_oe = 0;
  logic [31:0] exp_dq = '0;
  string       exp_tag = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic tick(input logic cen, ce1n, ce2, ce3n, adv, wen,
                      input logic [7:0] a, input logic [31:0] d, input logic [3:0] bw,
                      input string tag);
    logic nv;
    @(negedge clk);
    cen_ni = cen; ce1_ni = ce1n; ce2_i = ce2; ce3_ni = ce3n; adv_ld_i = adv;
    we_ni = wen; addr_i = a;
    if (!cen && b2_vld && b2_wr) begin dq_i = b2_d; bw_ni = b2_bw; end
    else begin dq_i = 32'hBAD0_BAD0 ^ {24'h0, a}; bw_ni = 4'h0; end
    @(posedge clk);
    if (!cen) begin
      if (b2_vld && b2_wr)
        for (int k = 0; k < 4; k++)
          if (!b2_bw[k]) ref_mem[b2_a][k*8 +: 8] = b2_d[k*8 +: 8];
      if (b1_vld && !b1_wr) begin
        exp_oe = 1; exp_dq = ref_mem[b1_a]; exp_tag = b1_tag;
      end else begin
        exp_oe = 0; exp_tag = (b1_vld && b1_wr) ? "R10" : tag;
      end
      nv = !ce1n && ce2 && !ce3n && !adv;
      b2_vld = b1_vld; b2_wr = b1_wr; b2_a = b1_a; b2_d = b1_d; b2_bw = b1_bw; b2_tag = b1_tag;
      b1_vld = nv; b1_wr = nv && !wen; b1_a = a; b1_d = d; b1_bw = bw; b1_tag = tag;
    end else exp_tag = tag;
    #(CLK_PERIOD/4);
    chk({exp_tag, " oe"}, {31'h0, dq_oe_o}, {31'h0, exp_oe});
    if (exp_oe) chk({exp_tag, " data"}, dq_o, exp_dq);
  endtask

  task automatic do_rd(input logic [7:0] a, input string tag);
    tick(0, 0, 1, 0, 0, 1, a, '0, 4'hF, tag);
  endtask
  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] bw,
                       input string tag);
    tick(0, 0, 1, 0, 0, 0, a, d, bw, tag);
  endtask
  task automatic do_nop(input string tag);
    tick(0, 1, 0, 1, 0, 1, 8'h0, '0, 4'hF, tag);
  endtask
  task automatic do_stall(input string tag);
    tick(1, 0, 1, 0, 0, 0, 8'h0, '0, 4'h0, tag);
  endtask

  task automatic t_reset();
    #(CLK_PERIOD/4);
    chk("R1 oe at reset", {31'h0, dq_oe_o}, 32'h0);
    chk("R1 dq at reset", dq_o, 32'h0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    do_nop("R1");
    do_nop("R1");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) do_wr(i[7:0], 32'h1111_0000 * i + 32'h0101 * i + 32'hA5, 4'h0, "R3");
    do_nop("R3"); do_nop("R3");
    for (int i = 0; i < 16; i++) do_rd(i[7:0], "R2");
    do_nop("R2"); do_nop("R2");
  endtask

  task automatic t_bytes();
    do_wr(8'd3, 32'hCAFE_F00D, 4'b1010, "R4");
    do_wr(8'd2, 32'h7788_99AA, 4'b0111, "R4");
    do_nop("R4"); do_nop("R4");
    do_rd(8'd3, "R4"); do_rd(8'd2, "R4");
    do_nop("R4");
  endtask

  task automatic t_abort();
    do_wr(8'd4, 32'hFFFF_FFFF, 4'hF, "R5");
    do_nop("R5"); do_nop("R5");
    do_rd(8'd4, "R5");
    do_nop("R5");
  endtask

  task automatic t_desel();
    tick(0, 1, 1, 0, 0, 1, 8'd5, '0, 4'hF, "R6");
    tick(0, 0, 0, 0, 0, 0, 8'd5, 32'h0BAD_0001, 4'h0, "R6");
    tick(0, 0, 1, 1, 0, 0, 8'd5, 32'h0BAD_0002, 4'h0, "R6");
    tick(0, 0, 1, 0, 1, 0, 8'd5, 32'h0BAD_0003, 4'h0, "R6");
    do_nop("R6"); do_nop("R6");
    do_rd(8'd5, "R6");
    do_nop("R6");
  endtask

  task automatic t_stall();
    do_wr(8'd6, 32'h5A5A_1234, 4'h0, "R7");
    do_stall("R7"); do_stall("R7"); do_stall("R7");
    do_nop("R7");
    do_stall("R7");
    do_nop("R7");
    do_rd(8'd6, "R7");
    do_rd(8'd7, "R7");
    do_stall("R7"); do_stall("R7");
    do_nop("R7"); do_nop("R7");
  endtask

  task automatic t_raw();
    do_wr(8'd8, 32'hDEAD_BEEF, 4'h0, "R9");
    do_rd(8'd8, "R9");
    do_wr(8'd9, 32'h1234_5678, 4'b0101, "R9");
    do_rd(8'd9, "R9");
    do_wr(8'd10, 32'h0F0F_0F0F, 4'h0, "R9");
    do_nop("R9");
    do_rd(8'd10, "R9");
    do_nop("R9"); do_nop("R9");
  endtask

  task automatic t_mix();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[4] && lfsr[9]) do_stall("R8");
      else if (lfsr[0]) do_wr({4'h0, lfsr[8:5]}, {lfsr, ~lfsr}, lfsr[13:10], "R8");
      else do_rd({4'h0, lfsr[8:5]}, "R8");
    end
    do_nop("R8"); do_nop("R8"); do_nop("R8");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    t_reset();
    t_fill();
    t_bytes();
    t_abort();
    t_desel();
    t_stall();
    t_raw();
    t_mix();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule